// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block holds the two threshold offsets that a FIFO's flag logic compares against: the almost-empty offset and the almost-full offset. A host loads them in one of two ways, chosen while master reset is held. The first is a serial stream, one bit per rising edge of a serial clock. The second is a series of parallel word writes on the data bus. The host can read both offsets back over the same bus at any time, whichever loading method is in force. A second reset-time choice selects a 9-bit or an 18-bit bus. In 9-bit mode each offset is 15 bits wide and takes two bus words. In 18-bit mode each offset is 14 bits wide and takes a single word.

All logic runs on `clk`. The serial clock is treated as a level that `clk` samples, and a low-to-high change of that sampled level counts as one serial edge. The parallel word pointer is a four-state machine:

- `SEQ_AE_LO`: low word of the almost-empty offset.
- `SEQ_AE_HI`: high word of the almost-empty offset.
- `SEQ_AF_LO`: low word of the almost-full offset.
- `SEQ_AF_HI`: high word of the almost-full offset.

Each accepted parallel write or read advances the pointer one step:

- 9-bit mode: AE_LO→AE_HI→AF_LO→AF_HI→AE_LO.
- 18-bit mode: AE_LO→AF_LO→AE_LO.

When `load` is high, the pointer returns to AE_LO instead of advancing. With `load` high, the enables are passed on as the FIFO memory's write and read strobes.

Top module: `ofl_offset_loader`

## Requirements
- R1: While `mrst_n` is low, at each clock edge the almost-empty and almost-full offsets become 7, `bus_dout` becomes 0, the serial bit index becomes 0 and the word pointer goes to AE_LO.
- R2: `cfg_serial` (1 = serial method) and `cfg_narrow` (1 = 9-bit bus) are captured only while `mrst_n` is low. Changing them afterwards has no effect until the next reset.
- R3: In serial mode with 9-bit bus, a serial step is requested when `load`=0, `wr_n`=1, `rd_n`=1 and `sh_n`=0. Each rising edge of `ser_clk` seen by `clk` during a step stores `ser_din` into exactly one bit. Bit indexes 0..14 fill the almost-empty offset from its LSB, and indexes 15..29 fill the almost-full offset, ending at its MSB.
- R4: In serial mode with 18-bit bus, a load is 28 bits: 14 into the almost-empty offset, then 14 into the almost-full offset. After the last bit, the index wraps to almost-empty bit 0.
- R5: In parallel mode with 9-bit bus, a write (`load`=0, `wr_n`=0) stores into the word the pointer selects, then advances the pointer. A low word takes `bus_din[8:0]` into offset bits 8:0. A high word takes `bus_din[5:0]` into offset bits 14:9. The order is AE low, AE high, AF low, AF high, then back to AE low.
- R6: In parallel mode with 18-bit bus, each write loads a whole offset from `bus_din[13:0]` and clears bit 14. The order is AE, then AF, then back to AE.
- R7: A read (`load`=0, `wr_n`=1, `rd_n`=0) places the selected word, zero-extended, on `bus_dout` one clock later and advances the pointer. Reads follow the same order as writes and work in either method. `bus_dout` changes at no other time outside reset.
- R8: With `load`=1, the pointer returns to AE_LO and the offsets hold. `mem_wr` equals `!wr_n` and `mem_rd` equals `!rd_n`, combinationally. Both strobes are 0 whenever `load`=0.
- R9: Serial steps do nothing in parallel mode. Parallel writes do nothing in serial mode and do not move the pointer.
- R10: With `load`=0 and `wr_n`, `rd_n`, `sh_n` all high, nothing changes. When `wr_n` and `rd_n` are both low, the write is performed and `bus_dout` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| cfg_serial | input | 1 | Method select captured in reset: 1 serial, 0 parallel |
| cfg_narrow | input | 1 | Bus width captured in reset: 1 for 9-bit, 0 for 18-bit |
| load | input | 1 | 0 selects offset access, 1 selects memory access |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| sh_n | input | 1 | Serial step enable, active low |
| ser_clk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_din | input | 1 | Serial data bit |
| bus_din | input | DATA_W | Parallel write data |
| offset_ae | output | OFS_W | Almost-empty offset |
| offset_af | output | OFS_W | Almost-full offset |
| bus_dout | output | DATA_W | Read-back word |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Narrow-mode high-word placement.** A design that put the high word at the wrong bit position would show a wrong almost-empty value after the second write.
- **Pointer wrap after the fourth word.** A design that failed to wrap would send the fifth write to a non-existent word.
- **Pointer reset by `load`.** A design that ignored `load` here would make a later read return the wrong word.
- **Wide-mode single-word step.** A design that kept the two-word sequence would let a third write land on the almost-full offset.
- **Serial boundary at 15 versus 14 bits.** A wrong boundary would shift the almost-full value by one bit.
- **Index wrap after bit 28 in wide mode.** A missing wrap would leave the almost-empty LSB unchanged.
- **Cross-method writes.** A design that accepted them would corrupt the offsets.
- **Simultaneous write and read enables.** Giving the read priority would alter `bus_dout`.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

    // Word pointer of the parallel access sequence
    typedef enum logic [1:0] {
        SEQ_AE_LO = 2'd0,
        SEQ_AE_HI = 2'd1,
        SEQ_AF_LO = 2'd2,
        SEQ_AF_HI = 2'd3
    } seq_state_e;

    // Offset-side operation decoded from the control inputs
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_SHIFT  = 3'd1,
        OP_PWRITE = 3'd2,
        OP_PREAD  = 3'd3,
        OP_MEM    = 3'd4
    } op_e;

endpackage

// File: rtl/ofl_decode.sv
module ofl_decode
    import ofl_pkg::*;
(
    input  logic load,
    input  logic wr_n,
    input  logic rd_n,
    input  logic sh_n,
    output op_e  op,
    output logic mem_wr,
    output logic mem_rd
);

    // Write enable outranks read enable, which outranks the serial step
    always_comb begin
        op = OP_IDLE;
        if (load) begin
            op = OP_MEM;
        end else if (!wr_n) begin
            op = OP_PWRITE;
        end else if (!rd_n) begin
            op = OP_PREAD;
        end else if (!sh_n) begin
            op = OP_SHIFT;
        end
    end

    always_comb begin
        mem_wr = load && !wr_n;
        mem_rd = load && !rd_n;
    end

endmodule

// File: rtl/ofl_seq_fsm.sv
module ofl_seq_fsm
    import ofl_pkg::*;
(
    input  logic clk,
    input  logic mrst_n,
    input  logic narrow,
    input  logic load,
    input  logic step,
    output logic sel_af,
    output logic sel_hi
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = SEQ_AE_LO;
        end else if (step) begin
            unique case (state_q)
                SEQ_AE_LO: state_d = narrow ? SEQ_AE_HI : SEQ_AF_LO;
                SEQ_AE_HI: state_d = SEQ_AF_LO;
                SEQ_AF_LO: state_d = narrow ? SEQ_AF_HI : SEQ_AE_LO;
                SEQ_AF_HI: state_d = SEQ_AE_LO;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state_q <= SEQ_AE_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs derived from the current state
    always_comb begin
        sel_af = 1'b0;
        sel_hi = 1'b0;
        unique case (state_q)
            SEQ_AE_LO: begin sel_af = 1'b0; sel_hi = 1'b0; end
            SEQ_AE_HI: begin sel_af = 1'b0; sel_hi = 1'b1; end
            SEQ_AF_LO: begin sel_af = 1'b1; sel_hi = 1'b0; end
            SEQ_AF_HI: begin sel_af = 1'b1; sel_hi = 1'b1; end
        endcase
    end

endmodule

// File: rtl/ofl_serial_ctr.sv
module ofl_serial_ctr #(
    parameter int OFS_W = 15,
    parameter int CNT_W = $clog2(2 * OFS_W)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             narrow,
    input  logic             shift_req,
    input  logic             ser_clk,
    output logic             shift_fire,
    output logic [CNT_W-1:0] bit_idx
);

    localparam logic [CNT_W-1:0] LAST_N = CNT_W'(2 * OFS_W - 1);
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(2 * (OFS_W - 1) - 1);

    logic             ser_clk_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] last_idx;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ser_clk_q <= 1'b0;
        end else begin
            ser_clk_q <= ser_clk;
        end
    end

    always_comb begin
        shift_fire = shift_req && ser_clk && !ser_clk_q;
        last_idx   = narrow ? LAST_N : LAST_W;
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            idx_q <= '0;
        end else if (shift_fire) begin
            idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
        end
    end

    assign bit_idx = idx_q;

endmodule

// File: rtl/ofl_offset_loader.sv
module ofl_offset_loader
    import ofl_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 15,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              cfg_serial,
    input  logic              cfg_narrow,
    input  logic              load,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              sh_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic [DATA_W-1:0] bus_din,
    output logic [OFS_W-1:0]  offset_ae,
    output logic [OFS_W-1:0]  offset_af,
    output logic [DATA_W-1:0] bus_dout,
    output logic              mem_wr,
    output logic              mem_rd
);

    localparam int NARROW_W   = DATA_W / 2;
    localparam int HI_W       = OFS_W - NARROW_W;
    localparam int WIDE_OFS_W = OFS_W - 1;
    localparam int CNT_W      = $clog2(2 * OFS_W);
    localparam int POS_W      = $clog2(OFS_W);
    localparam logic [CNT_W-1:0] HALF_N = CNT_W'(OFS_W);
    localparam logic [CNT_W-1:0] HALF_W = CNT_W'(WIDE_OFS_W);

    logic mode_ser_q;
    logic mode_nar_q;
    op_e  op;
    logic par_wr;
    logic par_rd;
    logic shift_req;
    logic shift_fire;
    logic sel_af;
    logic sel_hi;
    logic [CNT_W-1:0] bit_idx;
    logic [CNT_W-1:0] half;
    logic             ser_sel_af;
    logic [POS_W-1:0] ser_pos;
    logic [OFS_W-1:0] offs_q [2];
    logic [OFS_W-1:0] cur_ofs;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_q;
    logic unused_din_hi;

    // Reset-time configuration capture
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_ser_q <= cfg_serial;
            mode_nar_q <= cfg_narrow;
        end
    end

    ofl_decode dec_i (
        .load   (load),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .sh_n   (sh_n),
        .op     (op),
        .mem_wr (mem_wr),
        .mem_rd (mem_rd)
    );

    always_comb begin
        par_wr    = (op == OP_PWRITE) && !mode_ser_q;
        par_rd    = (op == OP_PREAD);
        shift_req = (op == OP_SHIFT) && mode_ser_q;
    end

    ofl_seq_fsm fsm_i (
        .clk    (clk),
        .mrst_n (mrst_n),
        .narrow (mode_nar_q),
        .load   (load),
        .step   (par_wr || par_rd),
        .sel_af (sel_af),
        .sel_hi (sel_hi)
    );

    ofl_serial_ctr #(
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) ctr_i (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .narrow     (mode_nar_q),
        .shift_req  (shift_req),
        .ser_clk    (ser_clk),
        .shift_fire (shift_fire),
        .bit_idx    (bit_idx)
    );

    // Serial index split into offset select and bit position
    always_comb begin
        half       = mode_nar_q ? HALF_N : HALF_W;
        ser_sel_af = (bit_idx >= half);
        ser_pos    = POS_W'(ser_sel_af ? (bit_idx - half) : bit_idx);
    end

    // One register per offset: index 0 almost-empty, index 1 almost-full
    for (genvar g = 0; g < 2; g++) begin : g_ofs
        localparam logic [OFS_W-1:0] DEF_V = (g == 0) ? OFS_W'(AE_DEF) : OFS_W'(AF_DEF);
        localparam logic IS_AF = (g == 1);

        always_ff @(posedge clk) begin
            if (!mrst_n) begin
                offs_q[g] <= DEF_V;
            end else if (shift_fire && (ser_sel_af == IS_AF)) begin
                offs_q[g][ser_pos] <= ser_din;
            end else if (par_wr && (sel_af == IS_AF)) begin
                if (mode_nar_q) begin
                    if (sel_hi) begin
                        offs_q[g][OFS_W-1:NARROW_W] <= bus_din[HI_W-1:0];
                    end else begin
                        offs_q[g][NARROW_W-1:0] <= bus_din[NARROW_W-1:0];
                    end
                end else begin
                    offs_q[g] <= {1'b0, bus_din[WIDE_OFS_W-1:0]};
                end
            end
        end
    end

    assign offset_ae = offs_q[0];
    assign offset_af = offs_q[1];

    // Read-back word selection
    always_comb begin
        cur_ofs = sel_af ? offs_q[1] : offs_q[0];
        if (mode_nar_q) begin
            rd_word = sel_hi ? DATA_W'(cur_ofs[OFS_W-1:NARROW_W])
                             : DATA_W'(cur_ofs[NARROW_W-1:0]);
        end else begin
            rd_word = DATA_W'(cur_ofs[WIDE_OFS_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            dout_q <= '0;
        end else if (par_rd) begin
            dout_q <= rd_word;
        end
    end

    assign bus_dout      = dout_q;
    assign unused_din_hi = ^bus_din[DATA_W-1:WIDE_OFS_W];

endmodule

// File: rtl/ofl_offset_loader_chk.sv
module ofl_offset_loader_chk #(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 15,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input logic              clk,
    input logic              mrst_n,
    input logic              load,
    input logic              wr_n,
    input logic              rd_n,
    input logic              sh_n,
    input logic              mode_ser_q,
    input logic              mode_nar_q,
    input logic [OFS_W-1:0]  offset_ae,
    input logic [OFS_W-1:0]  offset_af,
    input logic [DATA_W-1:0] bus_dout
);

    localparam logic [OFS_W-1:0] AE_V = OFS_W'(AE_DEF);
    localparam logic [OFS_W-1:0] AF_V = OFS_W'(AF_DEF);

    // R1
    reset_default_chk: assert property (@(posedge clk)
        !mrst_n |=> (offset_ae == AE_V && offset_af == AF_V && bus_dout == '0));

    // R2
    cfg_latch_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> ($stable(mode_ser_q) && $stable(mode_nar_q)));

    // R3
    one_bit_step_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_ser_q && $past(mrst_n)) |->
        ($countones({offset_af, offset_ae} ^ $past({offset_af, offset_ae})) <= 1));

    // R7
    dout_source_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !$stable(bus_dout) |-> $past(!load && wr_n && !rd_n));

    // R8
    load_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        load |=> ($stable(offset_ae) && $stable(offset_af)));

    // R9
    serial_wr_ignored_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_ser_q && !load && !wr_n) |=> ($stable(offset_ae) && $stable(offset_af)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (!load && wr_n && rd_n && sh_n) |=>
        ($stable(offset_ae) && $stable(offset_af) && $stable(bus_dout)));

endmodule

bind ofl_offset_loader ofl_offset_loader_chk #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .AE_DEF (AE_DEF),
    .AF_DEF (AF_DEF)
) chk_i (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .load       (load),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .sh_n       (sh_n),
    .mode_ser_q (mode_ser_q),
    .mode_nar_q (mode_nar_q),
    .offset_ae  (offset_ae),
    .offset_af  (offset_af),
    .bus_dout   (bus_dout)
);

// File: tb/ofl_offset_loader_tb.sv
module ofl_offset_loader_tb_top;

    logic        clk = 1'b0;
    logic        mrst_n;
    logic        cfg_serial;
    logic        cfg_narrow;
    logic        load;
    logic        wr_n;
    logic        rd_n;
    logic        sh_n;
    logic        ser_clk;
    logic        ser_din;
    logic [17:0] bus_din;
    logic [14:0] offset_ae;
    logic [14:0] offset_af;
    logic [17:0] bus_dout;
    logic        mem_wr;
    logic        mem_rd;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ofl_offset_loader dut_i (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .cfg_serial (cfg_serial),
        .cfg_narrow (cfg_narrow),
        .load       (load),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .sh_n       (sh_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .bus_din    (bus_din),
        .offset_ae  (offset_ae),
        .offset_af  (offset_af),
        .bus_dout   (bus_dout),
        .mem_wr     (mem_wr),
        .mem_rd     (mem_rd)
    );

    typedef struct packed {
        logic        is_rd;
        logic [17:0] din;
        logic [14:0] ae;
        logic [14:0] af;
        logic [17:0] dout;
    } vec_t;

    // Parallel, 9-bit bus: R5 write order and R7 read order
    localparam vec_t VECS [10] = '{
        '{1'b0, 18'h000AB, 15'h00AB, 15'h0007, 18'h00000},
        '{1'b0, 18'h00015, 15'h2AAB, 15'h0007, 18'h00000},
        '{1'b0, 18'h00123, 15'h2AAB, 15'h0123, 18'h00000},
        '{1'b0, 18'h0003F, 15'h2AAB, 15'h7F23, 18'h00000},
        '{1'b1, 18'h00000, 15'h2AAB, 15'h7F23, 18'h000AB},
        '{1'b1, 18'h00000, 15'h2AAB, 15'h7F23, 18'h00015},
        '{1'b1, 18'h00000, 15'h2AAB, 15'h7F23, 18'h00123},
        '{1'b1, 18'h00000, 15'h2AAB, 15'h7F23, 18'h0003F},
        '{1'b0, 18'h00001, 15'h2A01, 15'h7F23, 18'h0003F},
        '{1'b1, 18'h00000, 15'h2A01, 15'h7F23, 18'h00015}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        load = 1'b0; wr_n = 1'b1; rd_n = 1'b1; sh_n = 1'b1;
        ser_clk = 1'b0; ser_din = 1'b0; bus_din = '0;
    endtask

    task automatic do_reset(input logic ser, input logic nar);
        @(negedge clk);
        go_idle();
        cfg_serial = ser;
        cfg_narrow = nar;
        mrst_n = 1'b0;
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
        cfg_serial = ~ser;
        cfg_narrow = ~nar;
    endtask

    task automatic pwrite(input logic [17:0] d);
        wr_n = 1'b0; bus_din = d;
        @(negedge clk);
        go_idle();
    endtask

    task automatic pread();
        rd_n = 1'b0;
        @(negedge clk);
        go_idle();
    endtask

    task automatic shift_bit(input logic b);
        sh_n = 1'b0; ser_din = b; ser_clk = 1'b0;
        @(negedge clk);
        ser_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        go_idle();
    endtask

    task automatic shift_word(input logic [14:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            shift_bit(v[i]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        go_idle();
        mrst_n = 1'b0;
        cfg_serial = 1'b0;
        cfg_narrow = 1'b1;

        // Parallel method, 9-bit bus
        do_reset(1'b0, 1'b1);
        check("R1 ae default", 32'(offset_ae), 32'h7);
        check("R1 af default", 32'(offset_af), 32'h7);
        check("R1 dout reset", 32'(bus_dout), 32'h0);

        for (int i = 0; i < 10; i++) begin
            if (VECS[i].is_rd) pread(); else pwrite(VECS[i].din);
            check($sformatf("R5/R7 vec%0d ae", i), 32'(offset_ae), 32'(VECS[i].ae));
            check($sformatf("R5/R7 vec%0d af", i), 32'(offset_af), 32'(VECS[i].af));
            check($sformatf("R5/R7 vec%0d dout", i), 32'(bus_dout), 32'(VECS[i].dout));
        end

        // R8: memory strobes and pointer return
        load = 1'b1; wr_n = 1'b0;
        #1;
        check("R8 mem_wr", 32'(mem_wr), 32'h1);
        check("R8 mem_rd idle", 32'(mem_rd), 32'h0);
        @(negedge clk);
        go_idle();
        load = 1'b1; rd_n = 1'b0;
        #1;
        check("R8 mem_rd", 32'(mem_rd), 32'h1);
        @(negedge clk);
        go_idle();
        check("R8 ae held", 32'(offset_ae), 32'h2A01);
        pread();
        check("R8 pointer at AE low", 32'(bus_dout), 32'h001);

        // R2: config changed after reset, parallel write still accepted
        pwrite(18'h00000);
        check("R2 parallel kept", 32'(offset_ae), 32'h0001);

        // R9: serial steps ignored in parallel mode
        shift_word(15'h7FFF, 5);
        check("R9 serial ignored ae", 32'(offset_ae), 32'h0001);
        check("R9 serial ignored af", 32'(offset_af), 32'h7F23);

        // R10: idle cycles and write priority
        repeat (3) @(negedge clk);
        check("R10 idle dout", 32'(bus_dout), 32'h001);
        wr_n = 1'b0; rd_n = 1'b0; bus_din = 18'h000AA;
        @(negedge clk);
        go_idle();
        check("R10 write wins af", 32'(offset_af), 32'h7EAA);
        check("R10 write wins dout", 32'(bus_dout), 32'h001);

        // Serial method, 9-bit bus
        do_reset(1'b1, 1'b1);
        shift_word(15'h1234, 15);
        check("R3 ae after 15 bits", 32'(offset_ae), 32'h1234);
        check("R3 af untouched", 32'(offset_af), 32'h7);
        shift_word(15'h5A5A, 15);
        check("R3 af after 30 bits", 32'(offset_af), 32'h5A5A);
        check("R3 ae kept", 32'(offset_ae), 32'h1234);
        pwrite(18'h001FF);
        check("R9 parallel ignored ae", 32'(offset_ae), 32'h1234);
        check("R9 parallel ignored af", 32'(offset_af), 32'h5A5A);
        pread();
        check("R7 serial-mode read low", 32'(bus_dout), 32'h034);
        pread();
        check("R7 serial-mode read high", 32'(bus_dout), 32'h009);

        // Parallel method, 18-bit bus
        do_reset(1'b0, 1'b0);
        pwrite(18'h3EABC);
        check("R6 ae word", 32'(offset_ae), 32'h2ABC);
        pwrite(18'h01555);
        check("R6 af word", 32'(offset_af), 32'h1555);
        pwrite(18'h00011);
        check("R6 wrap to ae", 32'(offset_ae), 32'h0011);
        check("R6 af kept", 32'(offset_af), 32'h1555);
        pread();
        check("R7 wide read af", 32'(bus_dout), 32'h1555);
        pread();
        check("R7 wide read ae", 32'(bus_dout), 32'h0011);

        // Serial method, 18-bit bus
        do_reset(1'b1, 1'b0);
        shift_word(15'h3FFF, 14);
        check("R4 ae after 14 bits", 32'(offset_ae), 32'h3FFF);
        shift_word(15'h0001, 14);
        check("R4 af after 28 bits", 32'(offset_af), 32'h0001);
        shift_bit(1'b0);
        check("R4 index wraps", 32'(offset_ae), 32'h3FFE);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule